// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block turns a stream of stereo PCM sample pairs into a three-wire serial audio link: a word-select line, a bit clock and a serial data line. It runs on the system clock and advances only when a bit-clock tick input is high. Each tick toggles an internal phase. On every second tick the data bit and the word-select level move on, and the outgoing bit clock makes its inactive-going transition at that point. A receiver therefore samples on the opposite edge.

A format word is captured when the run enable rises, and it holds for the whole run. The format word sets the sample width (16 or 24 bits), the framing (standard I2S, left justified or right justified), the bit order, the word-select level for the left slot, the bit-clock polarity, the channel mode, and whether the pad bits of a right-justified slot carry the sign. Sample pairs arrive through a ready/valid handshake, one pair per frame. If no pair is offered at a frame boundary, the block sends silence for that frame and flags an underflow. A separate output enable forces the three link pins low while the internal timing keeps running.

Top module: `sat_tx`

## Requirements
- R1: After reset, and on the cycle after run_en is low, ws, sck, sdo, s_ready and underflow are all 0.
- R2: When cfg_wide is 1, the samples are 24 bits wide in slots of 26 bit clocks. When cfg_wide is 0, the samples use bits 15..0 in slots of 18 bit clocks.
- R3: Framing is selected by cfg_frame. Value 0 (standard I2S) starts the sample one bit clock into the slot. Value 1 (left justified) starts the sample at slot bit 0. Value 2 (right justified) places the sample so that its last bit is the last bit of the slot. Value 3 behaves as value 0.
- R4: Slot bits that carry no sample bit are 0. The one exception is right-justified framing with cfg_signed set: there, the leading pad bits repeat sample bit 23 (24-bit) or bit 15 (16-bit).
- R5: cfg_lsb_first 0 sends each sample most significant bit first. Value 1 sends it least significant bit first.
- R6: Each frame sends the left slot and then the right slot. During the left slot, ws equals cfg_ws_left_hi. During the right slot, ws is its inverse.
- R7: With cfg_sck_inv 0, ws and sdo change together with a falling edge of sck and hold across each rising edge. With cfg_sck_inv 1, sck is inverted, so ws and sdo hold across falling edges.
- R8: cfg_chan selects the channel mode. Value 0 (stereo) sends left, then right. Value 1 sends the right sample in both slots. Value 2 sends the left sample in both slots. Value 3 sends zeros, with ws and sck still running.
- R9: s_ready is high for exactly one cycle at each frame boundary, and only in a cycle where bclk_en is high. A pair is taken when s_valid and s_ready are both high.
- R10: If s_valid is low at a frame boundary, that frame's slots carry zeros and underflow is high for exactly one cycle.
- R11: The format inputs are captured when run_en rises. Changes to them while run_en stays high do not alter ws, sck or sdo.
- R12: While out_en is 0, ws, sck and sdo are 0, and frame timing (including s_ready) keeps running.
- R13: While running, ws, sck and sdo change only on cycles whose preceding clock edge saw bclk_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: 24-bit samples, 0: 16-bit samples |
| cfg_frame | input | 2 | Framing: 0 I2S, 1 left justified, 2 right justified, 3 as 0 |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_ws_left_hi | input | 1 | ws level during the left slot |
| cfg_sck_inv | input | 1 | 1: inverted bit clock |
| cfg_chan | input | 2 | 0 stereo, 1 right in both slots, 2 left in both slots, 3 mute |
| cfg_signed | input | 1 | Sign-fill the pad bits in right-justified framing |
| run_en | input | 1 | Run enable; its rising edge captures the format |
| out_en | input | 1 | Drives the link pins when high |
| bclk_en | input | 1 | Half-bit tick |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Pair taken this cycle if s_valid is high |
| s_left | input | 24 | Left sample |
| s_right | input | 24 | Right sample |
| ws | output | 1 | Word select |
| sck | output | 1 | Bit clock |
| sdo | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse: frame sent without a sample |

## Verification
Four things are checked on every cycle: the single-cycle shape of s_ready and underflow and their tie to the tick, the cause of each underflow, idle quiet after run_en drops, and the rule that the pins move only after ticks. The slot contents cannot be expressed as simple properties, so only the bench scenarios show them. That covers framing offsets, pad and sign fill, bit order, channel selection, ws polarity, the sampling edge of either clock polarity, and the freezing of the format during a run. The bench rebuilds each frame from the pins at the receiver's sampling edge and compares it with a frame built from the requirements.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int SMP_W    = 24;
    localparam int NARROW_W = 16;
    localparam int PAD_BITS = 2;
    localparam int SLOT_MAX = SMP_W + PAD_BITS;
    localparam int CNT_W    = $clog2(SLOT_MAX);
    localparam int IDX_W    = $clog2(SMP_W);

    typedef enum logic [1:0] {FR_I2S = 2'd0, FR_LEFT = 2'd1, FR_RIGHT = 2'd2, FR_RSVD = 2'd3} frame_e;
    typedef enum logic [1:0] {CH_STEREO = 2'd0, CH_ONLY_R = 2'd1, CH_ONLY_L = 2'd2, CH_MUTE = 2'd3} chan_e;

    typedef struct packed {
        logic   wide;
        frame_e frame;
        logic   lsb_first;
        logic   ws_left_hi;
        logic   sck_inv;
        chan_e  chan;
        logic   signed_pad;
    } fmt_t;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } pair_t;

    // number of bit clocks in one slot, minus one
    function automatic logic [CNT_W-1:0] last_bit(input logic wide);
        return wide ? CNT_W'(SMP_W + PAD_BITS - 1) : CNT_W'(NARROW_W + PAD_BITS - 1);
    endfunction

    // value on the data line at position k of a slot carrying smp
    function automatic logic slot_bit(input logic [SMP_W-1:0] smp, input fmt_t f,
                                      input logic [CNT_W-1:0] k);
        logic [CNT_W-1:0] n, off, j;
        logic [IDX_W-1:0] idx;
        n   = f.wide ? CNT_W'(SMP_W) : CNT_W'(NARROW_W);
        off = (f.frame == FR_RIGHT) ? CNT_W'(PAD_BITS) :
              (f.frame == FR_LEFT)  ? CNT_W'(0) : CNT_W'(1);
        if (k < off) begin
            idx = IDX_W'(n - CNT_W'(1));
            return (f.frame == FR_RIGHT && f.signed_pad) ? smp[idx] : 1'b0;
        end
        j = k - off;
        if (j >= n) return 1'b0;
        idx = f.lsb_first ? IDX_W'(j) : IDX_W'(n - CNT_W'(1) - j);
        return smp[idx];
    endfunction
endpackage

// File: rtl/sat_timing.sv
module sat_timing
    import sat_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_req,
    input  logic          bclk_en,
    input  logic [CW-1:0] slot_last,
    output logic          running,
    output logic          phase,
    output logic          advance,
    output logic          frame_start,
    output logic          nxt_right,
    output logic [CW-1:0] nxt_cnt
);
    logic          first_q;
    logic          right_q;
    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign advance     = running && bclk_en && phase;
    assign at_end      = (cnt_q == slot_last);
    assign frame_start = advance && (first_q || (right_q && at_end));

    always_comb begin
        if (frame_start) begin
            nxt_right = 1'b0;
            nxt_cnt   = '0;
        end else if (at_end) begin
            nxt_right = 1'b1;
            nxt_cnt   = '0;
        end else begin
            nxt_right = right_q;
            nxt_cnt   = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_req) begin
            running <= 1'b0;
            phase   <= 1'b0;
            first_q <= 1'b0;
            right_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!running) begin
            // start: next tick is a data step
            running <= 1'b1;
            phase   <= 1'b1;
            first_q <= 1'b1;
        end else if (bclk_en) begin
            phase <= !phase;
            if (advance) begin
                first_q <= 1'b0;
                right_q <= nxt_right;
                cnt_q   <= nxt_cnt;
            end
        end
    end
endmodule

// File: rtl/sat_sample.sv
module sat_sample
    import sat_pkg::*;
#(
    parameter int W = SMP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_req,
    input  logic         load,
    input  chan_e        chan,
    input  logic         s_valid,
    input  logic [W-1:0] s_left,
    input  logic [W-1:0] s_right,
    output logic [W-1:0] nxt_left,
    output logic [W-1:0] nxt_right,
    output logic         underflow
);
    logic [W-1:0] held_l, held_r;
    logic [W-1:0] pick_l, pick_r;

    always_comb begin
        unique case (chan)
            CH_ONLY_R: begin pick_l = s_right; pick_r = s_right; end
            CH_ONLY_L: begin pick_l = s_left;  pick_r = s_left;  end
            CH_MUTE:   begin pick_l = '0;      pick_r = '0;      end
            default:   begin pick_l = s_left;  pick_r = s_right; end
        endcase
        if (load) begin
            nxt_left  = s_valid ? pick_l : '0;
            nxt_right = s_valid ? pick_r : '0;
        end else begin
            nxt_left  = held_l;
            nxt_right = held_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_req) begin
            held_l    <= '0;
            held_r    <= '0;
            underflow <= 1'b0;
        end else begin
            held_l    <= nxt_left;
            held_r    <= nxt_right;
            underflow <= load && !s_valid;
        end
    end
endmodule

// File: rtl/sat_tx.sv
module sat_tx
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wide,
    input  logic [1:0]       cfg_frame,
    input  logic             cfg_lsb_first,
    input  logic             cfg_ws_left_hi,
    input  logic             cfg_sck_inv,
    input  logic [1:0]       cfg_chan,
    input  logic             cfg_signed,
    input  logic             run_en,
    input  logic             out_en,
    input  logic             bclk_en,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [SMP_W-1:0] s_left,
    input  logic [SMP_W-1:0] s_right,
    output logic             ws,
    output logic             sck,
    output logic             sdo,
    output logic             underflow
);
    fmt_t             fmt_q, fmt_in;
    logic             running, phase, advance, frame_start, nxt_right_slot;
    logic [CNT_W-1:0] nxt_cnt;
    logic [SMP_W-1:0] nxt_l, nxt_r;
    logic             ws_q, sdo_q;

    assign fmt_in = '{wide: cfg_wide, frame: frame_e'(cfg_frame), lsb_first: cfg_lsb_first,
                      ws_left_hi: cfg_ws_left_hi, sck_inv: cfg_sck_inv,
                      chan: chan_e'(cfg_chan), signed_pad: cfg_signed};

    // format is frozen on the start cycle
    always_ff @(posedge clk) begin
        if (rst) fmt_q <= '0;
        else if (run_en && !running) fmt_q <= fmt_in;
    end

    sat_timing #(.CW(CNT_W)) u_timing (
        .clk(clk), .rst(rst), .run_req(run_en), .bclk_en(bclk_en),
        .slot_last(last_bit(fmt_q.wide)), .running(running), .phase(phase),
        .advance(advance), .frame_start(frame_start),
        .nxt_right(nxt_right_slot), .nxt_cnt(nxt_cnt)
    );

    sat_sample #(.W(SMP_W)) u_sample (
        .clk(clk), .rst(rst), .run_req(run_en), .load(frame_start), .chan(fmt_q.chan),
        .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
        .nxt_left(nxt_l), .nxt_right(nxt_r), .underflow(underflow)
    );

    assign s_ready = frame_start;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            ws_q  <= 1'b0;
            sdo_q <= 1'b0;
        end else if (advance) begin
            ws_q  <= nxt_right_slot ? !fmt_q.ws_left_hi : fmt_q.ws_left_hi;
            sdo_q <= slot_bit(nxt_right_slot ? nxt_r : nxt_l, fmt_q, nxt_cnt);
        end
    end

    assign ws  = out_en && ws_q;
    assign sdo = out_en && sdo_q;
    assign sck = out_en && running && (phase ^ fmt_q.sck_inv);
endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk (
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic out_en,
    input logic bclk_en,
    input logic s_valid,
    input logic s_ready,
    input logic ws,
    input logic sck,
    input logic sdo,
    input logic underflow
);
    a_r9_ready_on_tick: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> bclk_en);

    a_r9_ready_single: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);

    a_r10_underflow_single: assert property (@(posedge clk) disable iff (rst)
        underflow |=> !underflow);

    a_r10_underflow_cause: assert property (@(posedge clk) disable iff (rst)
        underflow |-> $past(s_ready && !s_valid));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!s_ready && !underflow && !ws && !sck && !sdo));

    a_r13_pins_move_on_tick: assert property (@(posedge clk) disable iff (rst)
        (run_en && $past(run_en) && $past(run_en, 2) && !$past(bclk_en) && $stable(out_en))
        |-> ($stable(ws) && $stable(sck) && $stable(sdo)));
endmodule

bind sat_tx sat_tx_chk u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .out_en(out_en), .bclk_en(bclk_en),
    .s_valid(s_valid), .s_ready(s_ready), .ws(ws), .sck(sck), .sdo(sdo),
    .underflow(underflow)
);

// File: tb/sim_sat_tx.sv
module sim_sat_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wide = 1'b0, cfg_lsb_first = 1'b0, cfg_ws_left_hi = 1'b0;
    logic        cfg_sck_inv = 1'b0, cfg_signed = 1'b0;
    logic [1:0]  cfg_frame = 2'd0, cfg_chan = 2'd0;
    logic        run_en = 1'b0, out_en = 1'b0, bclk_en = 1'b0;
    logic        s_valid, s_ready, ws, sck, sdo, underflow;
    logic [23:0] s_left, s_right;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [23:0] pool_l [4];
    logic [23:0] pool_r [4];
    int          n_smp = 0;
    int          base  = 0;
    int          hs_cnt = 0;
    bit          cap_ws [160];
    bit          cap_sd [160];

    always #2 clk = !clk;

    sat_tx u0 (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_frame(cfg_frame),
        .cfg_lsb_first(cfg_lsb_first), .cfg_ws_left_hi(cfg_ws_left_hi),
        .cfg_sck_inv(cfg_sck_inv), .cfg_chan(cfg_chan), .cfg_signed(cfg_signed),
        .run_en(run_en), .out_en(out_en), .bclk_en(bclk_en), .s_valid(s_valid),
        .s_ready(s_ready), .s_left(s_left), .s_right(s_right), .ws(ws), .sck(sck),
        .sdo(sdo), .underflow(underflow)
    );

    // sample feeder: offers pool entries in order
    assign s_valid = (hs_cnt - base) < n_smp;
    assign s_left  = s_valid ? pool_l[(hs_cnt - base) & 3] : 24'h0;
    assign s_right = s_valid ? pool_r[(hs_cnt - base) & 3] : 24'h0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (s_valid && s_ready) hs_cnt <= hs_cnt + 1;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        wait (cycles > 150000);
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
        finish_run();
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // expected slot bit, written from the framing rules
    function automatic bit ref_bit(input logic [23:0] smp, input bit wide, input bit [1:0] fr,
                                   input bit lsb, input bit sg, input int k);
        int n, lead, j;
        n    = wide ? 24 : 16;
        lead = (fr == 2'd2) ? 2 : ((fr == 2'd1) ? 0 : 1);
        if (k < lead) return (fr == 2'd2 && sg) ? smp[n-1] : 1'b0;
        j = k - lead;
        if (j >= n) return 1'b0;
        return lsb ? smp[j] : smp[n-1-j];
    endfunction

    task automatic run_case(input bit wide, input bit [1:0] fr, input bit lsb, input bit wshi,
                            input bit inv, input bit [1:0] ch, input bit sg, input int nfr,
                            input int nsm, input bit gap, input bit chg, input string tag);
        int len, total, cap, uf, quiet_bad, hs0, bad_ws, bad_sd, first_bad;
        bit last_tick, psck, pws, psd;
        logic [23:0] smp;
        cfg_wide = wide; cfg_frame = fr; cfg_lsb_first = lsb; cfg_ws_left_hi = wshi;
        cfg_sck_inv = inv; cfg_chan = ch; cfg_signed = sg;
        for (int i = 0; i < 4; i++) begin
            pool_l[i] = 24'($urandom);
            pool_r[i] = 24'($urandom);
        end
        base = hs_cnt; n_smp = nsm; hs0 = hs_cnt;
        bclk_en = 1'b0; out_en = 1'b1; run_en = 1'b1;
        @(negedge clk);
        len = wide ? 26 : 18;
        total = 2 * len * nfr;
        cap = 0; uf = 0; quiet_bad = 0; last_tick = 1'b0;
        psck = sck; pws = ws; psd = sdo;
        while (cap < total && cycles < 140000) begin
            @(negedge clk);
            if (underflow) uf++;
            if (!last_tick && (ws != pws || sdo != psd || sck != psck)) quiet_bad++;
            if (sck != psck && sck == !inv) begin
                cap_ws[cap] = ws; cap_sd[cap] = sdo; cap++;
            end
            psck = sck; pws = ws; psd = sdo;
            if (chg && cap == total / 2) begin
                cfg_wide = !wide; cfg_frame = fr ^ 2'd1; cfg_lsb_first = !lsb;
                cfg_ws_left_hi = !wshi; cfg_sck_inv = !inv; cfg_chan = ch ^ 2'd3;
                cfg_signed = !sg;
            end
            last_tick = gap ? (($urandom % 3) != 0) : 1'b1;
            bclk_en = last_tick;
        end
        run_en = 1'b0; bclk_en = 1'b0;
        bad_ws = 0; bad_sd = 0; first_bad = -1;
        for (int f = 0; f < nfr; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < len; k++) begin
                    int p;
                    p = f * 2 * len + s * len + k;
                    if (f >= nsm || ch == 2'd3) smp = 24'h0;
                    else if (ch == 2'd1) smp = pool_r[f];
                    else if (ch == 2'd2) smp = pool_l[f];
                    else smp = s ? pool_r[f] : pool_l[f];
                    if (cap_ws[p] != (s ? !wshi : wshi)) bad_ws++;
                    if (cap_sd[p] != ref_bit(smp, wide, fr, lsb, sg, k)) begin
                        bad_sd++;
                        if (first_bad < 0) first_bad = p;
                    end
                end
            end
        end
        check(cap == total, {tag, " bit count"}, cap, total);
        check(bad_ws == 0, {tag, " R6 ws level mismatches"}, bad_ws, 0);
        check(bad_sd == 0, {tag, " sdo mismatches (first at bit)"}, first_bad, -1);
        check(quiet_bad == 0, {tag, " R13 pin change without tick"}, quiet_bad, 0);
        check(hs_cnt - hs0 == ((nsm < nfr) ? nsm : nfr), {tag, " R9 pairs taken"},
              hs_cnt - hs0, (nsm < nfr) ? nsm : nfr);
        check(uf == ((nfr > nsm) ? nfr - nsm : 0), {tag, " R10 underflow pulses"},
              uf, (nfr > nsm) ? nfr - nsm : 0);
        @(negedge clk);
        @(negedge clk);
        check({ws, sck, sdo, s_ready, underflow} == 5'b0, {tag, " R1 idle after stop"},
              int'({ws, sck, sdo, s_ready, underflow}), 0);
    endtask

    initial begin
        int seed_dummy;
        int oe_bad, hs_before;
        seed_dummy = $urandom(20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({ws, sck, sdo, s_ready, underflow} == 5'b0, "R1 reset state",
              int'({ws, sck, sdo, s_ready, underflow}), 0);

        // directed corner cases
        run_case(1, 2'd0, 0, 0, 0, 2'd0, 0, 3, 3, 0, 0, "I2S 24b msb R2 R3 R6");
        run_case(0, 2'd1, 1, 1, 0, 2'd0, 0, 3, 3, 1, 0, "LJ 16b lsb R3 R5");
        run_case(1, 2'd2, 0, 1, 1, 2'd0, 1, 3, 3, 1, 0, "RJ 24b signed inv R4 R7");
        run_case(0, 2'd2, 0, 0, 0, 2'd0, 0, 3, 3, 0, 0, "RJ 16b unsigned R2 R4");
        run_case(0, 2'd2, 1, 0, 1, 2'd0, 1, 2, 2, 1, 0, "RJ 16b signed lsb R4 R5 R7");
        run_case(1, 2'd1, 0, 0, 0, 2'd0, 1, 2, 2, 0, 0, "LJ ignores signed R4");
        run_case(1, 2'd3, 0, 1, 0, 2'd0, 0, 2, 2, 0, 0, "reserved framing R3");
        run_case(0, 2'd0, 0, 0, 0, 2'd1, 0, 2, 2, 1, 0, "mono right R8");
        run_case(1, 2'd0, 1, 1, 0, 2'd2, 0, 2, 2, 0, 0, "mono left R8");
        run_case(1, 2'd2, 0, 0, 0, 2'd3, 1, 2, 2, 1, 0, "mute R8");
        run_case(1, 2'd0, 0, 0, 0, 2'd0, 0, 3, 1, 0, 0, "starved R10");
        run_case(0, 2'd1, 0, 1, 0, 2'd0, 0, 2, 0, 1, 0, "no samples R10");
        run_case(1, 2'd2, 0, 0, 0, 2'd0, 1, 3, 3, 1, 1, "format frozen R11");

        // output enable low: pins quiet, timing still runs
        cfg_wide = 1'b0; cfg_frame = 2'd0; cfg_chan = 2'd0; cfg_sck_inv = 1'b1;
        base = hs_cnt; n_smp = 4; hs_before = hs_cnt; oe_bad = 0;
        out_en = 1'b0; run_en = 1'b1; bclk_en = 1'b1;
        repeat (200) begin
            @(negedge clk);
            if (ws || sck || sdo) oe_bad++;
        end
        check(oe_bad == 0, "R12 pins low with out_en off", oe_bad, 0);
        check(hs_cnt - hs_before >= 2, "R12 frames continue with out_en off",
              hs_cnt - hs_before, 2);
        run_en = 1'b0; bclk_en = 1'b0; out_en = 1'b1;
        repeat (2) @(negedge clk);

        // constrained random formats
        for (int t = 0; t < 8; t++) begin
            bit [1:0] fr_r;
            fr_r = 2'($urandom % 3);
            run_case(1'($urandom), fr_r, 1'($urandom), 1'($urandom), 1'($urandom),
                     2'($urandom), 1'($urandom), 2, 2, 1'($urandom), 0,
                     "random R2 R3 R4 R5 R6 R7 R8");
        end
        finish_run();
    end
endmodule